// File: doc/BRIEF.md
# Programmable Interrupt Source Router

This block collects a set of peripheral interrupt request lines and steers each one onto one of nine general-purpose priority inputs of a core event controller, covering core levels 7 through 15. Every source owns a 4-bit target field held in a software-writable register. Any number of sources may point at the same level, and the level output is then the OR of their requests. A per-source mask removes a source from the OR without touching its target field, and a read-only status word shows the raw request lines.

Software reaches the configuration through a small word-addressed read/write port. Reset loads a fixed default routing. The low sixteen sources go to level 7, the next two go to level 8, and the rest go to level 9. Every level output is registered.

Top module: `irq_source_router`

## Requirements
- R1: After reset, the level outputs are all 0 and the mask reads 0. Target fields read back 0 for sources 0..15, 1 for sources 16..17 and 2 for sources 18..23. The word at address 2 therefore reads 32'h22222211.
- R2: An asserted, unmasked source whose target field N is in 0..8 sets `lvl_irq[N]` (core level 7+N) on the clock edge after it is sampled.
- R3: A source whose target field holds a value from 9 to 15 drives no level output.
- R4: Sources that share a target field value are OR-combined: the level stays high while any one of them is asserted and unmasked.
- R5: Mask bit s set to 1 (mask word at address 8, bit s = source s) stops source s from reaching any level output.
- R6: The status word at address 9 returns the raw source lines (bit s = source s), whatever the mask holds.
- R7: Target field registers sit at addresses 0..2, with eight 4-bit fields per word and source 8*a+k in bits [4k+3:4k] of word a. Unused bits and unmapped addresses read 0. Read data appears on `bus_rdata` one cycle after `bus_rd_en` and holds when no read is issued.
- R8: Writes to the status address or to any unmapped address leave every target field and the mask unchanged.
- R9: A later reset restores the default routing and clears the mask, whatever writes came before it.
- R10: A configuration write takes effect on the edge where it is sampled. The level outputs reflect it one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_irq | input | 24 | Peripheral request lines, level sensitive |
| lvl_irq | output | 9 | Bit N drives core level 7+N |

## Verification
The assertions take the request lines to be already synchronous to `clk` and sampled as levels, and they take the bus strobes to be single-cycle controls with no ordering rule between a write and a read. The bench drives every input on the falling edge, so the requests and strobes are settled one half period before each rising edge. It mixes directed sequences with random request patterns and random writes that cover out-of-range field values, the status address and unmapped addresses.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int LVL_CNT     = 9;
  localparam int FLD_W       = 4;
  localparam int FLD_PER_REG = 8;
  localparam int ADDR_W      = 4;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 4'h8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 4'h9;

  // Reset routing: index below l8 -> field 0, below l9 -> field 1, else field 2
  function automatic logic [FLD_W-1:0] dflt_field(int idx, int l8, int l9);
    if (idx >= l9) return FLD_W'(2);
    if (idx >= l8) return FLD_W'(1);
    return '0;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_rt_pkg::*;
#(
  parameter int NUM_SRC  = 24,
  parameter int DATA_W   = 32,
  parameter int L8_FIRST = 16,
  parameter int L9_FIRST = 18
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NUM_SRC-1:0]        src_raw,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_SRC*FLD_W-1:0]  fld_flat,
  output logic [NUM_SRC-1:0]        mask_q
);
  localparam int NUM_ASG = (NUM_SRC + FLD_PER_REG - 1) / FLD_PER_REG;
  localparam int IMG_W   = NUM_ASG * DATA_W;

  logic [IMG_W-1:0]  asg_img;
  logic [DATA_W-1:0] rd_nxt;

  // one field register per source, its word and nibble fixed by its index
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_fld
    localparam int WORD = s / FLD_PER_REG;
    localparam int NIB  = s % FLD_PER_REG;
    logic [FLD_W-1:0] fld_r;
    always_ff @(posedge clk) begin
      if (rst)
        fld_r <= dflt_field(s, L8_FIRST, L9_FIRST);
      else if (wr_en && addr == ADDR_W'(WORD))
        fld_r <= wdata[NIB*FLD_W +: FLD_W];
    end
    assign fld_flat[s*FLD_W +: FLD_W] = fld_r;
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (wr_en && addr == MASK_ADDR)
      mask_q <= wdata[NUM_SRC-1:0];
  end

  assign asg_img = IMG_W'(fld_flat);

  always_comb begin
    rd_nxt = '0;
    for (int r = 0; r < NUM_ASG; r++)
      if (addr == ADDR_W'(r)) rd_nxt = asg_img[r*DATA_W +: DATA_W];
    if (addr == MASK_ADDR) rd_nxt = DATA_W'(mask_q);
    if (addr == STAT_ADDR) rd_nxt = DATA_W'(src_raw);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end
endmodule

// File: rtl/irq_src_steer.sv
module irq_src_steer
  import irq_rt_pkg::*;
(
  input  logic             req,
  input  logic             blocked,
  input  logic [FLD_W-1:0] fld,
  output logic [LVL_CNT-1:0] onehot
);
  always_comb begin
    onehot = '0;
    if (req && !blocked && fld < FLD_W'(LVL_CNT))
      onehot[fld] = 1'b1;
  end
endmodule

// File: rtl/irq_level_or.sv
module irq_level_or
  import irq_rt_pkg::*;
#(
  parameter int NUM_SRC = 24
) (
  input  logic [NUM_SRC*LVL_CNT-1:0] oh_flat,
  output logic [LVL_CNT-1:0]         lvl_any
);
  always_comb begin
    lvl_any = '0;
    for (int s = 0; s < NUM_SRC; s++)
      lvl_any |= oh_flat[s*LVL_CNT +: LVL_CNT];
  end
endmodule

// File: rtl/irq_source_router.sv
module irq_source_router
  import irq_rt_pkg::*;
#(
  parameter int NUM_SRC  = 24,
  parameter int DATA_W   = 32,
  parameter int L8_FIRST = 16,
  parameter int L9_FIRST = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [3:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0]  src_irq,
  output logic [8:0]          lvl_irq
);
  logic [NUM_SRC*FLD_W-1:0]   fld_w;
  logic [NUM_SRC-1:0]         mask_w;
  logic [NUM_SRC*LVL_CNT-1:0] oh_w;
  logic [LVL_CNT-1:0]         lvl_nxt;

  irq_cfg_regs #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W),
    .L8_FIRST(L8_FIRST), .L9_FIRST(L9_FIRST)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .src_raw(src_irq),
    .rdata(bus_rdata), .fld_flat(fld_w), .mask_q(mask_w)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_steer
    irq_src_steer u_steer (
      .req(src_irq[s]), .blocked(mask_w[s]),
      .fld(fld_w[s*FLD_W +: FLD_W]),
      .onehot(oh_w[s*LVL_CNT +: LVL_CNT])
    );
  end

  irq_level_or #(.NUM_SRC(NUM_SRC)) u_or (.oh_flat(oh_w), .lvl_any(lvl_nxt));

  always_ff @(posedge clk) begin
    if (rst) lvl_irq <= '0;
    else     lvl_irq <= lvl_nxt;
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_rt_pkg::*;
#(
  parameter int NUM_SRC  = 24,
  parameter int DATA_W   = 32,
  parameter int L8_FIRST = 16,
  parameter int L9_FIRST = 18
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_rd_en,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NUM_SRC-1:0]         src_irq,
  input logic [8:0]                 lvl_irq,
  input logic [NUM_SRC-1:0]         mask_q,
  input logic [NUM_SRC*FLD_W-1:0]   fld_q
);
  logic [NUM_SRC*FLD_W-1:0] dflt_img;
  always_comb
    for (int s = 0; s < NUM_SRC; s++)
      dflt_img[s*FLD_W +: FLD_W] = dflt_field(s, L8_FIRST, L9_FIRST);

  // R1 / R9: leaving reset, routing and mask are at their defaults
  a_r1_defaults_on_release: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (fld_q == dflt_img && mask_q == '0));

  // R2: no live request means no level output next cycle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ((src_irq & ~mask_q) == '0) |=> (lvl_irq == '0));

  // R5: full mask silences every level
  a_r5_full_mask: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> (lvl_irq == '0));

  // R10: any raised level traces back to a live request one cycle earlier
  a_r10_level_cause: assert property (@(posedge clk) disable iff (rst)
    (lvl_irq != '0) |-> ($past((src_irq & ~mask_q) != '0)));

  // R7: read data holds when no read is issued
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rdata));
endmodule

bind irq_source_router irq_router_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .L8_FIRST(L8_FIRST), .L9_FIRST(L9_FIRST)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
  .src_irq(src_irq), .lvl_irq(lvl_irq), .mask_q(mask_w), .fld_q(fld_w)
);

// File: tb/irq_source_router_tb_top.sv
`timescale 1ns/1ps
module irq_source_router_tb_top;
  localparam int NS = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NS-1:0] src = '0;
  logic [8:0]  lvl;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_source_router dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(wr), .bus_rd_en(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .src_irq(src), .lvl_irq(lvl)
  );

  // behavioural reference
  int          m_fld [NS];
  logic [NS-1:0] m_mask;
  logic [8:0]  m_lvl;
  logic [31:0] m_rd;

  function automatic int def_fld(int i);
    return (i < 16) ? 0 : (i < 18) ? 1 : 2;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    logic [31:0] v = '0;
    if (a < 3)
      for (int k = 0; k < 8; k++) v[k*4 +: 4] = 4'(m_fld[a*8+k]);
    else if (a == 4'h8) v = 32'(m_mask);
    else if (a == 4'h9) v = 32'(src);
    return v;
  endfunction

  always @(posedge clk) begin : model
    logic [8:0] nv;
    if (rst) begin
      for (int i = 0; i < NS; i++) m_fld[i] = def_fld(i);
      m_mask = '0; m_lvl = '0; m_rd = '0;
    end else begin
      nv = '0;
      for (int i = 0; i < NS; i++)
        if (src[i] && !m_mask[i] && m_fld[i] < 9) nv[m_fld[i]] = 1'b1;
      if (rd) m_rd = m_read(addr);
      if (wr) begin
        if (addr < 3)
          for (int k = 0; k < 8; k++) m_fld[addr*8+k] = int'(wdata[k*4 +: 4]);
        else if (addr == 4'h8) m_mask = wdata[NS-1:0];
      end
      m_lvl = nv;
    end
  end

  // per-cycle comparison (R2, R7)
  always @(negedge clk) if (!done) begin
    n_chk++;
    if (lvl !== m_lvl) begin
      n_bad++; $display("FAIL R2 model lvl act=%h exp=%h", lvl, m_lvl);
    end
    n_chk++;
    if (rdata !== m_rd) begin
      n_bad++; $display("FAIL R7 model rdata act=%h exp=%h", rdata, m_rd);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_src(logic [NS-1:0] v);
    @(negedge clk); src = v;
    @(negedge clk);
  endtask

  task automatic report();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      report();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 lvl after reset", 32'(lvl), 32'h0);
    rd_reg(4'd0, d); chk("R1 word0", d, 32'h0);
    rd_reg(4'd1, d); chk("R1 word1", d, 32'h0);
    rd_reg(4'd2, d); chk("R1 word2", d, 32'h22222211);
    rd_reg(4'h8, d); chk("R1 mask", d, 32'h0);
    rd_reg(4'h5, d); chk("R7 unmapped read", d, 32'h0);

    set_src(24'h000001); chk("R2 src0 to level7", 32'(lvl), 32'h001);
    set_src(24'h010000); chk("R2 src16 to level8", 32'(lvl), 32'h002);
    set_src(24'h100000); chk("R2 src20 to level9", 32'(lvl), 32'h004);
    set_src(24'h0);      chk("R2 idle", 32'(lvl), 32'h0);

    wr_reg(4'd0, 32'h0000_F098);   // src0->8, src1->9, src2->0, src3->15
    set_src(24'h000001); chk("R2 src0 to level15", 32'(lvl), 32'h100);
    set_src(24'h000002); chk("R3 field 9 unassigned", 32'(lvl), 32'h0);
    set_src(24'h000008); chk("R3 field 15 unassigned", 32'(lvl), 32'h0);

    set_src(24'h000030); chk("R4 shared level both", 32'(lvl), 32'h001);
    set_src(24'h000010); chk("R4 shared level one", 32'(lvl), 32'h001);

    wr_reg(4'h8, 32'h0000_0004);
    set_src(24'h000004); chk("R5 masked source", 32'(lvl), 32'h0);
    set_src(24'h000014); chk("R5 unmasked peer", 32'(lvl), 32'h001);
    rd_reg(4'h9, d); chk("R6 raw status", d, 32'h000014);

    wr_reg(4'h9, 32'hFFFF_FFFF);
    wr_reg(4'h7, 32'hFFFF_FFFF);
    rd_reg(4'd0, d); chk("R8 word0 untouched", d, 32'h0000_F098);
    rd_reg(4'h8, d); chk("R8 mask untouched", d, 32'h0000_0004);

    // R10: src4 held, retarget to level 12 (field 5)
    @(negedge clk); src = 24'h000010; wr = 1'b1; addr = 4'd0; wdata = 32'h0005_F098;
    @(negedge clk); wr = 1'b0;
    chk("R10 old routing one edge after write", 32'(lvl), 32'h001);
    @(negedge clk);
    chk("R10 new routing", 32'(lvl), 32'h020);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; src = '0;
    rd_reg(4'd0, d); chk("R9 word0 reloaded", d, 32'h0);
    rd_reg(4'h8, d); chk("R9 mask cleared", d, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      src = NS'($urandom);
      wr = ($urandom % 6) == 0; rd = ($urandom % 3) == 0;
      addr = 4'($urandom); wdata = $urandom;
    end
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    @(negedge clk);
    report();
  end
endmodule